// File: doc/BRIEF.md
# Low-Power Mode and Reset Sequencer

This block decides the operating state of a small microcontroller core and turns that state into enable signals. Software can ask for a light sleep, in which only the CPU stops, or a deep sleep, in which the oscillator stops and everything else stops with it. The block also qualifies the external reset pin. A reset counts only after the pin has stayed high for two machine cycles of oscillator ticks. An accepted reset produces a single-cycle pulse that reinitialises the special-function registers. On-chip RAM contents are never cleared by this block.

Light sleep ends on any pending interrupt whose enable is set, or on the reset pin. Deep sleep ends only through a qualified reset. While the oscillator is stopped, the qualifier counts a slow fallback tick instead of the oscillator tick. If the reset pin wakes the core from light sleep, the CPU runs again at once, but internal RAM access stays inhibited until the reset is accepted. Port access is not inhibited during that window. All clock stopping appears as enables, and the reset pin is taken as already synchronous to `clk_i`.

Top module: `pwr_rst_ctrl`

## Requirements
- R1: While and right after `rst_ni` is low, the block is in run mode: `cpu_clk_en_o`=1, `per_clk_en_o`=1, `osc_run_o`=1, `ram_inhibit_o`=0, `sfr_rst_o`=0.
- R2: A reset is accepted on the clock edge of the 24th qualifying tick (TICKS_PER_MC=12 times RST_MC=2) during which `rst_pin_i` is high. Any cycle with the pin low clears the count.
- R3: `sfr_rst_o` is high for exactly the one cycle after the accepting edge. It does not repeat while the pin stays high.
- R4: In run mode, `idle_req_i` makes the next cycle show `cpu_clk_en_o`=0, `per_clk_en_o`=1 and `osc_run_o`=1 (light sleep).
- R5: Light sleep returns to run mode one cycle after any bit is set in both `irq_pend_i` and `irq_en_i`. A pending bit whose enable is 0 has no effect.
- R6: In run mode, `pdown_req_i` makes the next cycle show `osc_run_o`=0, `cpu_clk_en_o`=0 and `per_clk_en_o`=0 (deep sleep). It wins when `idle_req_i` is high in the same cycle.
- R7: In deep sleep, enabled interrupts have no effect, and `osc_tick_i` does not advance the reset qualifier.
- R8: In deep sleep, the qualifier counts `slow_tick_i`. When it accepts, the block returns to run mode with all enables high and one `sfr_rst_o` pulse.
- R9: In light sleep, a high `rst_pin_i` makes the next cycle show `cpu_clk_en_o`=1 and `ram_inhibit_o`=1. The pin takes precedence over an interrupt arriving in the same cycle.
- R10: The inhibit window ends in run mode with `ram_inhibit_o`=0. On acceptance this comes with an `sfr_rst_o` pulse. If the pin falls first, it comes without one.
- R11: Cycles without a qualifying tick do not count toward R2, so with a tick on every other cycle, acceptance comes on the 47th edge, counted from the edge of the first tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| osc_tick_i | input | 1 | Oscillator tick enable, one per oscillator period |
| slow_tick_i | input | 1 | Fallback tick used while the oscillator is stopped |
| rst_pin_i | input | 1 | Reset pin level, synchronous to clk_i |
| idle_req_i | input | 1 | Software request for light sleep |
| pdown_req_i | input | 1 | Software request for deep sleep |
| irq_pend_i | input | IRQ_N | Pending interrupt flags |
| irq_en_i | input | IRQ_N | Interrupt enable flags |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| per_clk_en_o | output | 1 | Peripheral, timer, serial and interrupt logic clock enable |
| osc_run_o | output | 1 | Oscillator run enable |
| ram_inhibit_o | output | 1 | Blocks internal RAM access during the reset wake window |
| sfr_rst_o | output | 1 | One-cycle special-function register reset pulse |

## Verification
Every mode change and the reset pulse are registered once, so each result is visible in the cycle after the edge that samples its cause. The enables are decoded directly from the state register. The bench drives inputs on the falling edge and samples one falling edge later, which places each check in the first cycle after the responsible rising edge. Reset acceptance is checked edge by edge over the counting window. The pulse must appear after exactly the 24th qualifying tick and be absent before and after it, with tick patterns of every cycle, every other cycle and the slow fallback tick.

// File: rtl/pwr_rst_pkg.sv
package pwr_rst_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_IDLE  = 2'd1,
    ST_PDOWN = 2'd2,
    ST_WAKE  = 2'd3
  } pwr_state_e;

  typedef struct packed {
    logic cpu_en;
    logic per_en;
    logic osc_en;
    logic ram_inh;
  } pwr_en_t;
endpackage

// File: rtl/pr_rst_qual.sv
module pr_rst_qual #(
  parameter int TICKS_PER_MC = 12,
  parameter int RST_MC       = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic osc_run_i,
  input  logic osc_tick_i,
  input  logic slow_tick_i,
  input  logic pin_i,
  output logic accept_o
);
  localparam int RST_TICKS = TICKS_PER_MC * RST_MC;
  localparam int CW        = $clog2(RST_TICKS + 1);

  logic [CW-1:0] cnt_q;
  logic          tick;

  // fallback tick keeps the pin able to restart a stopped oscillator
  assign tick     = osc_run_i ? osc_tick_i : slow_tick_i;
  assign accept_o = pin_i && tick && (cnt_q == CW'(RST_TICKS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               cnt_q <= '0;
    else if (!pin_i)                           cnt_q <= '0;
    else if (tick && cnt_q != CW'(RST_TICKS))  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pr_irq_wake.sv
module pr_irq_wake #(
  parameter int IRQ_N = 5
) (
  input  logic [IRQ_N-1:0] pend_i,
  input  logic [IRQ_N-1:0] en_i,
  output logic             wake_o
);
  logic [IRQ_N-1:0] hit;

  for (genvar g = 0; g < IRQ_N; g++) begin : g_hit
    assign hit[g] = pend_i[g] & en_i[g];
  end

  assign wake_o = |hit;
endmodule

// File: rtl/pr_mode_fsm.sv
module pr_mode_fsm
  import pwr_rst_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       accept_i,
  input  logic       pin_i,
  input  logic       idle_req_i,
  input  logic       pdown_req_i,
  input  logic       irq_wake_i,
  output pwr_state_e state_o,
  output logic       sfr_rst_o
);
  pwr_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN: begin
        if (accept_i)         state_d = ST_RUN;
        else if (pdown_req_i) state_d = ST_PDOWN;
        else if (idle_req_i)  state_d = ST_IDLE;
      end
      ST_IDLE: begin
        if (accept_i)         state_d = ST_RUN;
        else if (pin_i)       state_d = ST_WAKE;
        else if (irq_wake_i)  state_d = ST_RUN;
      end
      ST_WAKE: begin
        if (accept_i || !pin_i) state_d = ST_RUN;
      end
      ST_PDOWN: begin
        if (accept_i)         state_d = ST_RUN;
      end
      default:                state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_RUN;
      sfr_rst_o <= 1'b0;
    end else begin
      state_q   <= state_d;
      sfr_rst_o <= accept_i;
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/pr_enable_dec.sv
module pr_enable_dec
  import pwr_rst_pkg::*;
(
  input  pwr_state_e state_i,
  output pwr_en_t    en_o
);
  always_comb begin
    unique case (state_i)
      ST_RUN:   en_o = '{cpu_en: 1'b1, per_en: 1'b1, osc_en: 1'b1, ram_inh: 1'b0};
      ST_IDLE:  en_o = '{cpu_en: 1'b0, per_en: 1'b1, osc_en: 1'b1, ram_inh: 1'b0};
      ST_WAKE:  en_o = '{cpu_en: 1'b1, per_en: 1'b1, osc_en: 1'b1, ram_inh: 1'b1};
      ST_PDOWN: en_o = '{cpu_en: 1'b0, per_en: 1'b0, osc_en: 1'b0, ram_inh: 1'b0};
      default:  en_o = '{cpu_en: 1'b1, per_en: 1'b1, osc_en: 1'b1, ram_inh: 1'b0};
    endcase
  end
endmodule

// File: rtl/pwr_rst_ctrl.sv
module pwr_rst_ctrl
  import pwr_rst_pkg::*;
#(
  parameter int IRQ_N        = 5,
  parameter int TICKS_PER_MC = 12,
  parameter int RST_MC       = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             osc_tick_i,
  input  logic             slow_tick_i,
  input  logic             rst_pin_i,
  input  logic             idle_req_i,
  input  logic             pdown_req_i,
  input  logic [IRQ_N-1:0] irq_pend_i,
  input  logic [IRQ_N-1:0] irq_en_i,
  output logic             cpu_clk_en_o,
  output logic             per_clk_en_o,
  output logic             osc_run_o,
  output logic             ram_inhibit_o,
  output logic             sfr_rst_o
);
  pwr_state_e state;
  pwr_en_t    en;
  logic       accept;
  logic       irq_wake;

  pr_rst_qual #(
    .TICKS_PER_MC(TICKS_PER_MC),
    .RST_MC      (RST_MC)
  ) u_qual (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .osc_run_i  (en.osc_en),
    .osc_tick_i (osc_tick_i),
    .slow_tick_i(slow_tick_i),
    .pin_i      (rst_pin_i),
    .accept_o   (accept)
  );

  pr_irq_wake #(.IRQ_N(IRQ_N)) u_wake (
    .pend_i(irq_pend_i),
    .en_i  (irq_en_i),
    .wake_o(irq_wake)
  );

  pr_mode_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (accept),
    .pin_i      (rst_pin_i),
    .idle_req_i (idle_req_i),
    .pdown_req_i(pdown_req_i),
    .irq_wake_i (irq_wake),
    .state_o    (state),
    .sfr_rst_o  (sfr_rst_o)
  );

  pr_enable_dec u_dec (
    .state_i(state),
    .en_o   (en)
  );

  assign cpu_clk_en_o  = en.cpu_en;
  assign per_clk_en_o  = en.per_en;
  assign osc_run_o     = en.osc_en;
  assign ram_inhibit_o = en.ram_inh;
endmodule

// File: rtl/pwr_rst_ctrl_chk.sv
module pwr_rst_ctrl_chk #(
  parameter int IRQ_N = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rst_pin_i,
  input logic             idle_req_i,
  input logic             pdown_req_i,
  input logic [IRQ_N-1:0] irq_pend_i,
  input logic [IRQ_N-1:0] irq_en_i,
  input logic             cpu_clk_en_o,
  input logic             per_clk_en_o,
  input logic             osc_run_o,
  input logic             ram_inhibit_o,
  input logic             sfr_rst_o
);
  logic run_mode, idle_mode;
  assign run_mode  = cpu_clk_en_o && osc_run_o && !ram_inhibit_o;
  assign idle_mode = !cpu_clk_en_o && osc_run_o;

  assert_pulse_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sfr_rst_o |=> !sfr_rst_o);

  assert_pulse_needs_pin_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sfr_rst_o |-> $past(rst_pin_i));

  assert_idle_entry_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_mode && idle_req_i && !pdown_req_i && !rst_pin_i) |=>
      (!cpu_clk_en_o && per_clk_en_o && osc_run_o));

  assert_irq_wake_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_mode && |(irq_pend_i & irq_en_i) && !rst_pin_i) |=> (cpu_clk_en_o && !ram_inhibit_o));

  assert_pdown_entry_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_mode && pdown_req_i && !rst_pin_i) |=> !osc_run_o);

  assert_pdown_all_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !osc_run_o |-> (!cpu_clk_en_o && !per_clk_en_o && !ram_inhibit_o));

  assert_pdown_exit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !osc_run_o |=> (!osc_run_o || sfr_rst_o));

  assert_wake_window_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_mode && rst_pin_i && !sfr_rst_o) |=> (cpu_clk_en_o && (ram_inhibit_o || sfr_rst_o)));

  assert_inhibit_exit_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ram_inhibit_o) |-> (cpu_clk_en_o && osc_run_o));
endmodule

bind pwr_rst_ctrl pwr_rst_ctrl_chk #(.IRQ_N(IRQ_N)) u_chk (.*);

// File: tb/pwr_rst_ctrl_bench.sv
module pwr_rst_ctrl_bench;
  localparam int IRQ_N = 5;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             osc_tick_i = 1'b1;
  logic             slow_tick_i = 1'b0;
  logic             rst_pin_i = 1'b0;
  logic             idle_req_i = 1'b0;
  logic             pdown_req_i = 1'b0;
  logic [IRQ_N-1:0] irq_pend_i = '0;
  logic [IRQ_N-1:0] irq_en_i = '0;
  logic             cpu_clk_en_o, per_clk_en_o, osc_run_o, ram_inhibit_o, sfr_rst_o;

  int checks = 0;
  int errors = 0;

  always #5 clk_i = ~clk_i;

  pwr_rst_ctrl #(.IRQ_N(IRQ_N)) u_pwr_rst_ctrl (
    .clk_i, .rst_ni, .osc_tick_i, .slow_tick_i, .rst_pin_i, .idle_req_i,
    .pdown_req_i, .irq_pend_i, .irq_en_i, .cpu_clk_en_o, .per_clk_en_o,
    .osc_run_o, .ram_inhibit_o, .sfr_rst_o
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // {cpu, per, osc, inhibit}
  function automatic int outs();
    return {cpu_clk_en_o, per_clk_en_o, osc_run_o, ram_inhibit_o};
  endfunction

  task automatic step();
    @(negedge clk_i);
  endtask

  task automatic t_reset_state();
    chk("R1 outputs in reset", outs(), 4'b1110);
    chk("R1 pulse in reset", sfr_rst_o, 0);
    step(); rst_ni = 1'b1;
    step();
    chk("R1 outputs after reset", outs(), 4'b1110);
    chk("R1 pulse after reset", sfr_rst_o, 0);
  endtask

  task automatic t_short_pin();
    int pulses = 0;
    for (int k = 0; k < 2; k++) begin
      rst_pin_i = 1'b1;
      for (int i = 1; i <= 23; i++) begin step(); pulses += sfr_rst_o; end
      rst_pin_i = 1'b0;
      step(); pulses += sfr_rst_o;
    end
    chk("R2 23 ticks twice with a low gap", pulses, 0);
  endtask

  task automatic t_full_reset();
    rst_pin_i = 1'b1;
    for (int i = 1; i <= 30; i++) begin
      step();
      chk($sformatf("R3 pulse after edge %0d", i), sfr_rst_o, (i == 24) ? 1 : 0);
    end
    chk("R2 run mode after reset", outs(), 4'b1110);
    rst_pin_i = 1'b0;
    step();
  endtask

  task automatic t_gated_ticks();
    int at = 0;
    int n = 0;
    rst_pin_i = 1'b1;
    for (int i = 1; i <= 60; i++) begin
      osc_tick_i = (i % 2 == 1);
      step();
      if (sfr_rst_o) begin n++; at = i; end
    end
    chk("R11 pulse count with half ticks", n, 1);
    chk("R11 pulse edge with half ticks", at, 47);
    rst_pin_i = 1'b0; osc_tick_i = 1'b1;
    step();
  endtask

  task automatic t_idle_irq();
    idle_req_i = 1'b1; step(); idle_req_i = 1'b0;
    chk("R4 idle outputs", outs(), 4'b0110);
    irq_pend_i = 5'b00100; irq_en_i = 5'b00011;
    step(); step(); step();
    chk("R5 disabled irq ignored", outs(), 4'b0110);
    irq_en_i = 5'b00100;
    step();
    chk("R5 enabled irq wakes", outs(), 4'b1110);
    chk("R5 no pulse on irq wake", sfr_rst_o, 0);
    irq_pend_i = '0; irq_en_i = '0;
  endtask

  task automatic t_pdown();
    int pulses = 0;
    idle_req_i = 1'b1; pdown_req_i = 1'b1; step();
    idle_req_i = 1'b0; pdown_req_i = 1'b0;
    chk("R6 power-down wins over idle", outs(), 4'b0000);
    irq_pend_i = '1; irq_en_i = '1;
    step(); step(); step();
    chk("R7 irq ignored in power-down", outs(), 4'b0000);
    irq_pend_i = '0; irq_en_i = '0;
    rst_pin_i = 1'b1; osc_tick_i = 1'b1; slow_tick_i = 1'b0;
    for (int i = 0; i < 30; i++) begin step(); pulses += sfr_rst_o; end
    chk("R7 osc ticks ignored in power-down", outs(), 4'b0000);
    chk("R7 no pulse without slow ticks", pulses, 0);
    slow_tick_i = 1'b1;
    for (int i = 1; i <= 24; i++) begin
      step();
      if (i == 23) chk("R8 still down after 23 slow ticks", osc_run_o, 0);
    end
    chk("R8 run after 24 slow ticks", outs(), 4'b1110);
    chk("R8 pulse on power-down exit", sfr_rst_o, 1);
    rst_pin_i = 1'b0; slow_tick_i = 1'b0;
    step();
  endtask

  task automatic t_idle_reset();
    idle_req_i = 1'b1; step(); idle_req_i = 1'b0;
    rst_pin_i = 1'b1; irq_pend_i = 5'b00001; irq_en_i = 5'b00001;
    step();
    chk("R9 pin beats irq, inhibit window", outs(), 4'b1111);
    irq_pend_i = '0; irq_en_i = '0;
    for (int i = 2; i <= 24; i++) begin
      step();
      if (i == 23) begin
        chk("R9 inhibit held at edge 23", ram_inhibit_o, 1);
        chk("R9 no pulse at edge 23", sfr_rst_o, 0);
      end
    end
    chk("R10 run after accepted reset", outs(), 4'b1110);
    chk("R10 pulse ends window", sfr_rst_o, 1);
    rst_pin_i = 1'b0; step();
  endtask

  task automatic t_idle_glitch();
    idle_req_i = 1'b1; step(); idle_req_i = 1'b0;
    rst_pin_i = 1'b1;
    for (int i = 0; i < 5; i++) step();
    chk("R9 inhibit during short pin", outs(), 4'b1111);
    rst_pin_i = 1'b0;
    step();
    chk("R10 run after pin falls", outs(), 4'b1110);
    chk("R10 no pulse after pin falls", sfr_rst_o, 0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(); step();
    t_reset_state();
    t_short_pin();
    t_full_reset();
    t_gated_ticks();
    t_idle_irq();
    t_pdown();
    t_idle_reset();
    t_idle_glitch();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule